// File: doc/BRIEF.md
# Virtual-Channel Wormhole Input Port

This block is the receive side of one router port. Flits arrive on a single physical link, each tagged with a virtual-channel number and a kind (head, body, tail or a one-flit packet). Each virtual channel has its own small FIFO, so a packet that is stuck on one channel leaves the other channels free to move. The destination is read only from a packet's head flit. The output it selects is kept for that channel until the packet's tail has left, so body and tail flits follow the head whatever their payload holds.

Each channel shows its oldest flit and the output it wants. One arbiter per output grants at most one channel per cycle, and only when that output is ready. A granted flit leaves its FIFO at the next clock edge. A parameter can name one channel as high priority. The other channels share each output in round-robin order. Once a multi-flit packet holds an output, that output stays with it until its tail is granted. The crossbar datapath that moves the granted flit is not part of this block.

Top module: `vc_input_port`

## Requirements
- R1: Flit kinds are encoded 00 body, 01 head, 10 tail and 11 one-flit packet. An accepted flit on `in_vc` = v is stored in channel v's FIFO. That channel presents its flits on `vc_valid`, `vc_kind` and `vc_payload` in arrival order, starting in the cycle after the write edge.
- R2: When a head or one-flit packet is at the front of a channel, `vc_route` for that channel equals payload bits [1:0] of that flit.
- R3: After a head flit of a multi-flit packet has been granted, the body and tail flits of that packet present the head's route on `vc_route`, and their own payload bits [1:0] have no effect.
- R4: When a tail flit has been granted, the stored route is dropped, and the channel's next head takes its route from its own payload.
- R5: A flit that arrives for a channel already holding 4 flits (counted at the start of the cycle) raises `err_full` in that same cycle and is dropped. The channel's stored flits are unchanged.
- R6: A channel whose front flit is blocked on one output does not prevent a flit on another channel from being granted to a different ready output in the same cycle.
- R7: `out_gnt` bit o*4+v means channel v is granted output o. Each output grants at most one channel per cycle, and only when `out_ready[o]` is 1 and that channel's front flit requests o. The granted flit is removed at the next clock edge.
- R8: Among channels other than the priority channel, each output grants round-robin. The search starts at the channel after the last one granted, and starts at channel 0 after reset.
- R9: When the priority channel (channel 0 by default) requests a ready, unlocked output, it is granted ahead of every other channel.
- R10: Once a head flit of a multi-flit packet is granted an output, that output grants no other channel until the same channel's tail flit has been granted.
- R11: After reset all channels are empty: `vc_valid`, `out_gnt` and `err_full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming flit present this cycle |
| in_kind | input | 2 | Incoming flit kind |
| in_vc | input | 2 | Incoming flit virtual channel |
| in_payload | input | 32 | Incoming flit payload (head destination in bits [1:0]) |
| out_ready | input | 4 | Per-output downstream ready |
| vc_valid | output | 4 | Channel v has a flit at its front |
| vc_kind | output | 8 | Front flit kind, 2 bits per channel |
| vc_payload | output | 128 | Front flit payload, 32 bits per channel |
| vc_route | output | 8 | Requested output, 2 bits per channel |
| out_gnt | output | 16 | Grant matrix, bit o*4+v |
| err_full | output | 1 | Flit arrived for a full channel and was dropped |

## Verification
A one-flit packet on an open path shows that write, route and grant line up in time. A head, body and tail whose later flits carry misleading destination bits separates a held route from a route recomputed on every flit. Two channels aimed at different outputs, one of them blocked, show that the channels are independent. Several channels loaded while an output is held back and then released show the round-robin order, priority beating a pointer that favours another channel, and an output held by a packet that is only partly delivered. Filling one channel beyond its depth and then draining it shows that the extra flit is dropped and that the error is flagged.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
   typedef enum logic [1:0] {
      FLIT_BODY = 2'b00,
      FLIT_HEAD = 2'b01,
      FLIT_TAIL = 2'b10,
      FLIT_SOLO = 2'b11
   } flit_kind_e;
endpackage

// File: rtl/vcp_vc_buf.sv
module vcp_vc_buf #(
   parameter int DEPTH    = 4,
   parameter int DATA_W   = 32,
   parameter int OUT_W    = 2,
   parameter int DEST_LSB = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [1:0]        push_kind,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic              front_vld,
   output logic [1:0]        front_kind,
   output logic [DATA_W-1:0] front_data,
   output logic [OUT_W-1:0]  req_route,
   output logic              full
);
   import vcp_pkg::*;
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("vcp_vc_buf: DEPTH must be a power of two, at least 2");
   end
   if (DEST_LSB + OUT_W > DATA_W) begin : g_bad_dest
      $error("vcp_vc_buf: destination field exceeds payload");
   end

   logic [DATA_W+1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [AW:0]       count;
   logic              push_ok;
   logic [OUT_W-1:0]  route_q;
   logic              route_vld;

   assign full       = (count == CNT_FULL);
   assign push_ok    = push && !full;
   assign front_vld  = (count != '0);
   assign front_kind = mem[rd_ptr][DATA_W+1:DATA_W];
   assign front_data = mem[rd_ptr][DATA_W-1:0];
   assign req_route  = route_vld ? route_q : front_data[DEST_LSB +: OUT_W];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= {push_kind, push_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop)     rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // route captured from a departing head, released by a departing tail
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q   <= '0;
         route_vld <= 1'b0;
      end else if (pop) begin
         if (front_kind == FLIT_HEAD) begin
            route_q   <= front_data[DEST_LSB +: OUT_W];
            route_vld <= 1'b1;
         end else if (front_kind == FLIT_TAIL) begin
            route_vld <= 1'b0;
         end
      end
   end

   p_pop_has_flit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> front_vld);
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> (count == ($past(pop) ? $past(count) - 1'b1 : $past(count))));
   p_route_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (route_vld && !pop) |=> (route_vld && $stable(route_q)));
endmodule

// File: rtl/vcp_out_arb.sv
module vcp_out_arb #(
   parameter int NUM_VC  = 4,
   parameter int PRIO_VC = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_VC-1:0]   req,
   input  logic [NUM_VC*2-1:0] kind_flat,
   input  logic                ready,
   output logic [NUM_VC-1:0]   gnt
);
   import vcp_pkg::*;
   localparam int IW = $clog2(NUM_VC);

   if (NUM_VC < 2 || (NUM_VC & (NUM_VC - 1)) != 0) begin : g_bad_vc
      $error("vcp_out_arb: NUM_VC must be a power of two, at least 2");
   end

   logic [NUM_VC-1:0] elig, prio_gnt, rr_gnt, free_gnt;
   logic [IW-1:0]     ptr, owner, gnt_idx;
   logic [1:0]        gnt_kind;
   logic              locked;

   assign elig = ready ? req : '0;

   if (PRIO_VC >= 0 && PRIO_VC < NUM_VC) begin : g_prio
      assign prio_gnt = elig[PRIO_VC] ? (NUM_VC'(1) << PRIO_VC) : '0;
      p_prio_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (!locked && elig[PRIO_VC]) |-> gnt[PRIO_VC]);
   end else begin : g_flat
      assign prio_gnt = '0;
   end

   always_comb begin
      logic [IW-1:0] idx;
      logic          found;
      rr_gnt = '0;
      found  = 1'b0;
      for (int k = 0; k < NUM_VC; k++) begin
         idx = ptr + IW'(k);
         if (!found && elig[idx]) begin
            rr_gnt[idx] = 1'b1;
            found       = 1'b1;
         end
      end
   end

   assign free_gnt = (prio_gnt != '0) ? prio_gnt : rr_gnt;
   assign gnt      = locked ? (elig & (NUM_VC'(1) << owner)) : free_gnt;

   always_comb begin
      gnt_idx  = '0;
      gnt_kind = FLIT_BODY;
      for (int v = 0; v < NUM_VC; v++) begin
         if (gnt[v]) begin
            gnt_idx  = IW'(v);
            gnt_kind = kind_flat[v*2 +: 2];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         owner  <= '0;
         locked <= 1'b0;
      end else if (gnt != '0) begin
         if (!locked) ptr <= gnt_idx + 1'b1;
         if (gnt_kind == FLIT_HEAD) begin
            locked <= 1'b1;
            owner  <= gnt_idx;
         end else if (gnt_kind == FLIT_TAIL) begin
            locked <= 1'b0;
         end
      end
   end

   p_onehot_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   p_gnt_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   p_gnt_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (gnt == '0));
   p_lock_after_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && gnt_kind == FLIT_HEAD) |=> (gnt & ~$past(gnt)) == '0);
endmodule

// File: rtl/vc_input_port.sv
module vc_input_port #(
   parameter int NUM_VC    = 4,
   parameter int DEPTH     = 4,
   parameter int PAYLOAD_W = 32,
   parameter int NUM_OUT   = 4,
   parameter int DEST_LSB  = 0,
   parameter int PRIO_VC   = 0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 in_valid,
   input  logic [1:0]                           in_kind,
   input  logic [$clog2(NUM_VC)-1:0]            in_vc,
   input  logic [PAYLOAD_W-1:0]                 in_payload,
   input  logic [NUM_OUT-1:0]                   out_ready,
   output logic [NUM_VC-1:0]                    vc_valid,
   output logic [NUM_VC*2-1:0]                  vc_kind,
   output logic [NUM_VC*PAYLOAD_W-1:0]          vc_payload,
   output logic [NUM_VC*$clog2(NUM_OUT)-1:0]    vc_route,
   output logic [NUM_OUT*NUM_VC-1:0]            out_gnt,
   output logic                                 err_full
);
   localparam int OUT_W = $clog2(NUM_OUT);

   if (NUM_OUT < 2 || (NUM_OUT & (NUM_OUT - 1)) != 0) begin : g_bad_out
      $error("vc_input_port: NUM_OUT must be a power of two, at least 2");
   end

   logic [NUM_VC-1:0] full, pop;

   assign err_full = in_valid && full[in_vc];

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      vcp_vc_buf #(
         .DEPTH(DEPTH), .DATA_W(PAYLOAD_W), .OUT_W(OUT_W), .DEST_LSB(DEST_LSB)
      ) i_buf (
         .clk        (clk),
         .rst_n      (rst_n),
         .push       (in_valid && (in_vc == v)),
         .push_kind  (in_kind),
         .push_data  (in_payload),
         .pop        (pop[v]),
         .front_vld  (vc_valid[v]),
         .front_kind (vc_kind[v*2 +: 2]),
         .front_data (vc_payload[v*PAYLOAD_W +: PAYLOAD_W]),
         .req_route  (vc_route[v*OUT_W +: OUT_W]),
         .full       (full[v])
      );
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      logic [NUM_VC-1:0] req_o;
      for (genvar v = 0; v < NUM_VC; v++) begin : g_req
         assign req_o[v] = vc_valid[v] && (vc_route[v*OUT_W +: OUT_W] == o);
      end
      vcp_out_arb #(.NUM_VC(NUM_VC), .PRIO_VC(PRIO_VC)) i_arb (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req_o),
         .kind_flat (vc_kind),
         .ready     (out_ready[o]),
         .gnt       (out_gnt[o*NUM_VC +: NUM_VC])
      );
   end

   always_comb begin
      pop = '0;
      for (int o = 0; o < NUM_OUT; o++) pop |= out_gnt[o*NUM_VC +: NUM_VC];
   end

   for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
      logic [NUM_OUT-1:0] col;
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_col
         assign col[o] = out_gnt[o*NUM_VC + v];
      end
      p_one_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col));
   end

   p_err_means_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_full |-> (in_valid && (vc_valid[in_vc])));
endmodule

// File: tb/test_vc_input_port.sv
module test_vc_input_port;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] K_BODY = 2'b00, K_HEAD = 2'b01, K_TAIL = 2'b10, K_SOLO = 2'b11;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   in_kind = '0;
   logic [1:0]   in_vc = '0;
   logic [31:0]  in_payload = '0;
   logic [3:0]   out_ready = '0;
   logic [3:0]   vc_valid;
   logic [7:0]   vc_kind;
   logic [127:0] vc_payload;
   logic [7:0]   vc_route;
   logic [15:0]  out_gnt;
   logic         err_full;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   vc_input_port i_vc_input_port (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_vc(in_vc), .in_payload(in_payload), .out_ready(out_ready),
      .vc_valid(vc_valid), .vc_kind(vc_kind), .vc_payload(vc_payload),
      .vc_route(vc_route), .out_gnt(out_gnt), .err_full(err_full)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] pay(int v); return vc_payload[v*32 +: 32]; endfunction
   function automatic logic [1:0]  rte(int v); return vc_route[v*2 +: 2]; endfunction
   function automatic logic [1:0]  knd(int v); return vc_kind[v*2 +: 2]; endfunction
   function automatic logic [3:0]  gnt(int o); return out_gnt[o*4 +: 4]; endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      in_valid = 1'b0; out_ready = '0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // called at a negedge; returns at the next negedge with the flit stored
   task automatic send(logic [1:0] vc, logic [1:0] kind, logic [31:0] data);
      in_valid = 1'b1; in_vc = vc; in_kind = kind; in_payload = data;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R11 vc_valid after reset", vc_valid, 4'h0);
      chk("R11 out_gnt after reset", out_gnt, 16'h0);
      chk("R11 err_full after reset", err_full, 1'b0);
   endtask

   task automatic t_single();
      do_reset();
      out_ready = 4'hF;
      send(2'd1, K_SOLO, 32'h0000_0012);
      chk("R1 solo stored on vc1", vc_valid, 4'b0010);
      chk("R2 solo route from payload", rte(1), 2'd2);
      chk("R7 solo granted on output 2", out_gnt, 16'h0200);
      @(negedge clk);
      chk("R7 solo removed after grant", vc_valid, 4'b0000);
   endtask

   task automatic t_route_hold();
      do_reset();
      send(2'd2, K_HEAD, 32'h0000_0003);
      send(2'd2, K_BODY, 32'hAAAA_AAA0);
      send(2'd2, K_TAIL, 32'h5555_5551);
      chk("R1 head kind at front", knd(2), K_HEAD);
      chk("R2 head route", rte(2), 2'd3);
      chk("R7 no grant while not ready", out_gnt, 16'h0);
      out_ready = 4'b1000;
      #1;
      chk("R7 head granted on output 3", gnt(3), 4'b0100);
      @(negedge clk);
      chk("R1 body follows head", pay(2), 32'hAAAA_AAA0);
      chk("R3 body uses held route", rte(2), 2'd3);
      chk("R3 body granted on output 3", gnt(3), 4'b0100);
      @(negedge clk);
      chk("R1 tail follows body", pay(2), 32'h5555_5551);
      chk("R3 tail uses held route", rte(2), 2'd3);
      @(negedge clk);
      chk("R4 channel empty after tail", vc_valid[2], 1'b0);
      out_ready = 4'h0;
      send(2'd2, K_SOLO, 32'h0000_0002);
      chk("R4 next packet uses own route", rte(2), 2'd2);
   endtask

   task automatic t_hol();
      do_reset();
      out_ready = 4'b1110;
      send(2'd0, K_HEAD, 32'h0000_0000);
      send(2'd1, K_SOLO, 32'h0000_0001);
      chk("R6 blocked output gives no grant", gnt(0), 4'b0000);
      chk("R6 other channel granted", gnt(1), 4'b0010);
      @(negedge clk);
      chk("R6 blocked channel still holds its head", vc_valid, 4'b0001);
   endtask

   task automatic t_full();
      do_reset();
      for (int i = 0; i < 4; i++) begin
         in_valid = 1'b1; in_vc = 2'd3; in_kind = K_SOLO; in_payload = 32'h101 + i*4;
         #1;
         chk("R5 no error below depth", err_full, 1'b0);
         @(negedge clk);
      end
      in_payload = 32'h1FD;
      #1;
      chk("R5 error on full channel", err_full, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 4'b0010;
      for (int i = 0; i < 4; i++) begin
         #1;
         chk("R5 stored flits unchanged", pay(3), 32'h101 + i*4);
         @(negedge clk);
      end
      chk("R5 dropped flit not stored", vc_valid[3], 1'b0);
   endtask

   task automatic t_round_robin();
      do_reset();
      send(2'd1, K_SOLO, 32'h100);
      send(2'd1, K_SOLO, 32'h104);
      send(2'd2, K_SOLO, 32'h200);
      send(2'd2, K_SOLO, 32'h204);
      out_ready = 4'b0001;
      #1; chk("R8 first grant vc1", gnt(0), 4'b0010);
      @(negedge clk); chk("R8 second grant vc2", gnt(0), 4'b0100);
      @(negedge clk); chk("R8 third grant vc1", gnt(0), 4'b0010);
      chk("R1 vc1 second flit", pay(1), 32'h104);
      @(negedge clk); chk("R8 fourth grant vc2", gnt(0), 4'b0100);
      @(negedge clk); chk("R8 all drained", vc_valid, 4'b0000);
   endtask

   task automatic t_priority();
      do_reset();
      out_ready = 4'b0001;
      send(2'd1, K_SOLO, 32'h0);
      @(negedge clk);
      out_ready = 4'b0000;
      send(2'd3, K_SOLO, 32'h0);
      send(2'd0, K_SOLO, 32'h0);
      out_ready = 4'b0001;
      #1; chk("R9 priority channel first", gnt(0), 4'b0001);
      @(negedge clk); chk("R9 then rr channel", gnt(0), 4'b1000);
   endtask

   task automatic t_lock();
      do_reset();
      send(2'd1, K_HEAD, 32'h0);
      send(2'd2, K_SOLO, 32'h0);
      out_ready = 4'b0001;
      #1; chk("R10 head granted", gnt(0), 4'b0010);
      @(negedge clk);
      chk("R10 output held for open packet", gnt(0), 4'b0000);
      chk("R10 waiting channel still loaded", vc_valid, 4'b0100);
      send(2'd1, K_BODY, 32'h7);
      chk("R10 body granted on locked output", gnt(0), 4'b0010);
      send(2'd1, K_TAIL, 32'h0);
      chk("R10 tail granted on locked output", gnt(0), 4'b0010);
      @(negedge clk);
      chk("R10 released after tail", gnt(0), 4'b0100);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      t_reset();
      t_single();
      t_route_hold();
      t_hol();
      t_full();
      t_round_robin();
      t_priority();
      t_lock();
      finish_run();
   end
endmodule